// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs serial management transactions towards up to 32 PHY devices over a two-wire clock and data bus. Each device holds 32 registers of 16 bits. A host asks for an access by pulsing a request with a read or write flag, a 5-bit device address, a 5-bit register address and, for writes, 16-bit data. The block divides the system clock to make the management clock. It shifts out a 32-bit frame, turns the data line around on reads, and returns read data with a one-cycle done pulse.

The bidirectional data line is split into an output, an output enable and an input. A resynchronisation frame of 32 one bits can be sent on host request at any idle time. One is also sent automatically after reset, and no transaction is accepted before it completes.

Top module: `mdio_master`

## Requirements
- R1: After reset release the block sends a 32-ones frame by itself. `ready_o` stays low until that frame has ended, and it raises no `done_o` for it.
- R2: A write frame is the 32 bits start 0,1, opcode 0,1, device address, register address, turnaround 1,0 and write data. Every field is sent MSB first, with the output enable high for all 32 bits.
- R3: A read frame sends start 0,1, opcode 1,0, device address and register address with the enable high. The enable goes low from the first turnaround bit on. The 16 bits sampled from `mdio_i` in bit times 16..31 form `rdata_o`, MSB first.
- R4: `mdc_o` is high for MDC_HALF_DIV system clocks and low for MDC_HALF_DIV system clocks, so consecutive rising edges are 2*MDC_HALF_DIV clocks apart. Each frame has exactly 32 rising edges, and `mdc_o` stays low while idle.
- R5: `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low; the device samples them on the rising edge.
- R6: `ready_o` is low from the cycle after a request is taken until the frame ends. Requests and reset-frame requests made while it is low are ignored.
- R7: A read or write ends with `done_o` high for exactly one cycle. `ready_o` is high in that cycle, and on a read `rdata_o` is valid in it.
- R8: A pulse on `rst_frame_req_i` while idle sends 32 one bits with the enable high and raises no `done_o`.
- R9: If `req_i` and `rst_frame_req_i` are both high in an idle cycle, only the 32-ones frame is sent and the transaction request is dropped.
- R10: `mdio_oe_o` is low whenever `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, taken when ready |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Device address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rst_frame_req_i | input | 1 | Request a 32-ones frame |
| ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 16 | Read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The transaction request and the reset-frame request can arrive in the same idle cycle. They can also collide with a frame already in flight. The bench raises both inputs on one clock edge while idle. It judges the outcome by the 32 bits captured on MDC rising edges: they must all be ones, with no done pulse and no transaction frame afterwards. It also fires both requests in the middle of a write, then checks that the captured frame is unchanged and that the bus stays released afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int RX_FIRST   = FRAME_BITS - DATA_BITS;  // first sampled bit time
  localparam int TA_FIRST   = RX_FIRST - 2;            // first turnaround bit time
  localparam logic [1:0] START_BITS = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == LAST);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  initial assert (HALF_DIV >= 2) else $error("HALF_DIV must be at least 2");

  a_r4_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  input  logic        rst_frame_req_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        run_o,
  output logic        ready_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] RX_BIT   = IW'(RX_FIRST);
  localparam logic [IW-1:0] PRE_TA   = IW'(TA_FIRST - 1);

  logic                  busy_q, init_q, is_rd_q, is_rst_q;
  logic [FRAME_BITS-1:0] sh_q, frame;
  logic [IW-1:0]         bit_q;
  logic [DATA_BITS-1:0]  rx_q;

  assign frame = {START_BITS, rd_i ? OP_READ : OP_WRITE, phy_addr_i, reg_addr_i,
                  rd_i ? 2'b11 : TA_WRITE, rd_i ? {DATA_BITS{1'b1}} : wdata_i};

  assign run_o   = busy_q;
  assign ready_o = !busy_q && !init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      init_q    <= 1'b1;
      is_rd_q   <= 1'b0;
      is_rst_q  <= 1'b0;
      sh_q      <= '0;
      bit_q     <= '0;
      rx_q      <= '0;
      rdata_o   <= '0;
      done_o    <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        // reset frame has priority over a transaction in the same cycle
        if (init_q || rst_frame_req_i) begin
          busy_q    <= 1'b1;
          init_q    <= 1'b0;
          is_rst_q  <= 1'b1;
          is_rd_q   <= 1'b0;
          sh_q      <= '1;
          bit_q     <= '0;
          mdio_o    <= 1'b1;
          mdio_oe_o <= 1'b1;
        end else if (req_i) begin
          busy_q    <= 1'b1;
          is_rst_q  <= 1'b0;
          is_rd_q   <= rd_i;
          sh_q      <= frame;
          bit_q     <= '0;
          mdio_o    <= frame[FRAME_BITS-1];
          mdio_oe_o <= 1'b1;
        end
      end else begin
        if (rise_i && is_rd_q && bit_q >= RX_BIT)
          rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
        if (fall_i) begin
          if (bit_q == LAST_BIT) begin
            busy_q    <= 1'b0;
            mdio_oe_o <= 1'b0;
            mdio_o    <= 1'b1;
            done_o    <= !is_rst_q;
            if (is_rd_q) rdata_o <= rx_q;
          end else begin
            bit_q     <= bit_q + 1'b1;
            sh_q      <= {sh_q[FRAME_BITS-2:0], 1'b0};
            mdio_o    <= sh_q[FRAME_BITS-2];
            mdio_oe_o <= !(is_rd_q && bit_q >= PRE_TA);
          end
        end
      end
    end
  end

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  a_r10_oe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mdio_oe_o);
  a_r1_no_done_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> !done_o && !ready_o);
  a_r8_rst_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && is_rst_q) |-> (mdio_o && mdio_oe_o));
  a_r3_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && is_rd_q && bit_q > PRE_TA) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int MDC_HALF_DIV = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  input  logic        rst_frame_req_i,
  output logic        ready_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic run, rise, fall;

  mdio_clk_gen #(.HALF_DIV(MDC_HALF_DIV)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .rd_i           (rd_i),
    .phy_addr_i     (phy_addr_i),
    .reg_addr_i     (reg_addr_i),
    .wdata_i        (wdata_i),
    .rst_frame_req_i(rst_frame_req_i),
    .rise_i         (rise),
    .fall_i         (fall),
    .mdio_i         (mdio_i),
    .run_o          (run),
    .ready_o        (ready_o),
    .done_o         (done_o),
    .rdata_o        (rdata_o),
    .mdio_o         (mdio_o),
    .mdio_oe_o      (mdio_oe_o)
  );

  a_r5_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  a_r6_busy_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> !ready_o);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rd = 1'b0, rreq = 1'b0;
  logic [4:0] pa = '0, ra = '0;
  logic [15:0] wd = '0, rpat = '0;
  logic ready, done, mdc, mdio_out, mdio_oe, mdio_in;
  logic [15:0] rdata;

  int n_tests = 0, n_fail = 0;

  always #10 clk = !clk;

  mdio_master #(.MDC_HALF_DIV(HD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd),
    .phy_addr_i(pa), .reg_addr_i(ra), .wdata_i(wd), .rst_frame_req_i(rreq),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // frame monitor: captures bits on MDC rising edges
  int rcnt = 0, cyc = 0, last_rise = 0, gap_err = 0, cur_done = 0;
  logic [31:0] cur_bits = '0, cur_oe = '0;
  logic mdc_prev = 1'b0;
  int snap_n = 0, snap_gap = 0, snap_done = 0, snap_cnt = 0;
  logic [31:0] snap_bits = '0, snap_oe = '0;

  always_comb begin
    mdio_in = 1'b1;
    if (rcnt >= 16 && rcnt < 32) mdio_in = rpat[31 - rcnt];
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc && !mdc_prev) begin
      cur_bits = {cur_bits[30:0], mdio_out};
      cur_oe   = {cur_oe[30:0], mdio_oe};
      if (rcnt > 0 && (cyc - last_rise) != 2 * HD) gap_err = gap_err + 1;
      last_rise = cyc;
      rcnt = rcnt + 1;
    end
    mdc_prev = mdc;
    if (done) cur_done = cur_done + 1;
    if (ready && rcnt != 0) begin
      snap_n = rcnt; snap_bits = cur_bits; snap_oe = cur_oe;
      snap_gap = gap_err; snap_done = cur_done; snap_cnt = snap_cnt + 1;
      rcnt = 0; gap_err = 0; cur_done = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_frame(input int s0);
    while (snap_cnt == s0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic xact(input bit r, input logic [4:0] p, input logic [4:0] a,
                      input logic [15:0] d, input logic [15:0] rp);
    int s0;
    logic [31:0] exp_bits;
    logic [15:0] got;
    while (!ready) @(negedge clk);
    s0 = snap_cnt;
    rpat = rp;
    rd = r; pa = p; ra = a; wd = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(ready == 1'b0, "R6 ready low after accept", {31'd0, ready}, 32'd0);
    while (!done) @(negedge clk);
    got = rdata;
    chk(ready == 1'b1, "R7 ready with done", {31'd0, ready}, 32'd1);
    wait_frame(s0);
    chk(snap_n == 32, "R4 rising edge count", snap_n, 32);
    chk(snap_gap == 0, "R4 MDC period", snap_gap, 0);
    chk(snap_done == 1, "R7 single done", snap_done, 1);
    if (!r) begin
      exp_bits = {2'b01, 2'b01, p, a, 2'b10, d};
      chk(snap_bits == exp_bits, "R2 write frame", snap_bits, exp_bits);
      chk(snap_oe == 32'hFFFF_FFFF, "R2 write enable", snap_oe, 32'hFFFF_FFFF);
    end else begin
      exp_bits = {2'b01, 2'b10, p, a, 18'd0};
      chk(snap_bits[31:18] == exp_bits[31:18], "R3 read header", snap_bits, exp_bits);
      chk(snap_oe == 32'hFFFC_0000, "R3 read release", snap_oe, 32'hFFFC_0000);
      chk(got == rp, "R3 read data", {16'd0, got}, {16'd0, rp});
    end
  endtask

  task automatic idle_check(input string tag);
    bit bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (mdio_oe || mdc || !ready || done) bad = 1;
    end
    chk(!bad, tag, {31'd0, bad}, 32'd0);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(!ready && !done && !mdc && !mdio_oe, "R1 reset state",
        {28'd0, ready, done, mdc, mdio_oe}, 32'd0);
    s0 = snap_cnt;
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0, "R1 not ready before init frame", {31'd0, ready}, 32'd0);
    // a request during the init frame must be ignored (R6)
    rd = 1'b0; pa = 5'd7; ra = 5'd7; wd = 16'h1234; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_frame(s0);
    chk(snap_bits == 32'hFFFF_FFFF && snap_n == 32, "R1 init frame ones", snap_bits, 32'hFFFF_FFFF);
    chk(snap_oe == 32'hFFFF_FFFF, "R1 init frame enable", snap_oe, 32'hFFFF_FFFF);
    chk(snap_done == 0, "R1 no done on init", snap_done, 0);
    idle_check("R6 request during init dropped");

    for (int i = 0; i < 32; i++)
      xact(1'b0, 5'(i), 5'(31 - i), 16'((i * 16'h0841) ^ 16'hA5C3), 16'h0);
    for (int i = 0; i < 32; i++)
      xact(1'b1, 5'(i), 5'((i * 7) % 32), 16'h0, 16'((i * 16'h1111) ^ 16'h8001 ^ (1 << (i % 16))));
    xact(1'b1, 5'd31, 5'd31, 16'h0, 16'hFFFF);
    xact(1'b1, 5'd0, 5'd0, 16'h0, 16'h0000);

    // standalone reset frame (R8)
    s0 = snap_cnt;
    rreq = 1'b1;
    @(negedge clk);
    rreq = 1'b0;
    wait_frame(s0);
    chk(snap_bits == 32'hFFFF_FFFF && snap_n == 32, "R8 reset frame ones", snap_bits, 32'hFFFF_FFFF);
    chk(snap_oe == 32'hFFFF_FFFF, "R8 reset frame enable", snap_oe, 32'hFFFF_FFFF);
    chk(snap_done == 0, "R8 no done", snap_done, 0);

    // both requests in one idle cycle (R9)
    s0 = snap_cnt;
    rd = 1'b0; pa = 5'd3; ra = 5'd9; wd = 16'h0F0F;
    req = 1'b1; rreq = 1'b1;
    @(negedge clk);
    req = 1'b0; rreq = 1'b0;
    wait_frame(s0);
    chk(snap_bits == 32'hFFFF_FFFF, "R9 reset frame wins", snap_bits, 32'hFFFF_FFFF);
    chk(snap_done == 0, "R9 no done", snap_done, 0);
    idle_check("R9 transaction dropped");

    // requests while busy are ignored (R6)
    s0 = snap_cnt;
    rd = 1'b0; pa = 5'd21; ra = 5'd10; wd = 16'hBEEF; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (40) @(negedge clk);
    rd = 1'b1; pa = 5'd1; ra = 5'd2; wd = 16'h0000; req = 1'b1; rreq = 1'b1;
    @(negedge clk);
    req = 1'b0; rreq = 1'b0;
    wait_frame(s0);
    chk(snap_bits == {2'b01, 2'b01, 5'd21, 5'd10, 2'b10, 16'hBEEF}, "R6 frame unchanged",
        snap_bits, {2'b01, 2'b01, 5'd21, 5'd10, 2'b10, 16'hBEEF});
    idle_check("R6 busy requests dropped R10 idle");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end
endmodule